// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block turns a small set of asynchronous external interrupt pins into clean, clock-synchronous interrupt requests. Each pin first passes through a synchronizer. A trigger detector then looks for a rising edge, a falling edge, either edge, a high level or a low level on that pin. The condition to look for is selected by a 4-bit code per pin. A detected condition is held in a per-pin pending bit. When the matching enable bit is also set, the pending bit raises that pin's request output one cycle later. The request output feeds one source line of an interrupt controller.

Software reaches the unit through a simple 32-bit register port with four word locations:

- a packed trigger-code register;
- a node-control word, which reads as zero;
- the pending bits, which are cleared by writing zeros;
- the enable bits.

Reads are combinational from the address. Writes take effect on the clock edge on which the write strobe is sampled.

Top module: `eit_unit`

## Requirements
- R1: The four word locations are: trigger codes at byte offset 0x00, node control at 0x04, pending at 0x08 and enables at 0x0C. Pin i's code sits in trigger-register bits [4i+3:4i]. While reset is held, the trigger register reads 0x666666 (low-level mode on every pin), pending and enable read 0, and every request output is 0.
- R2: Each pin passes through a two-stage synchronizer. A pin change that creates a trigger condition first shows in the pending bit after the third rising clock edge following the change. It shows on the request output after the fourth.
- R3: Code 1 sets the pending bit on a 0-to-1 transition of the synchronized pin. Code 2 sets it on a 1-to-0 transition, and code 3 on either transition. In these modes a set pending bit stays set until software clears it.
- R4: Code 5 (high level) and code 6 (low level) make the pending bit follow whether the synchronized pin is at its active level. A clear written while the level is active has no lasting effect, and the bit drops once the level goes inactive.
- R5: Codes 0, 4 and 7 to 15 never set the pending bit, whatever the pin does.
- R6: A write to offset 0x08 clears every pending bit written as 0 and leaves bits written as 1 unchanged, so a write can never set a bit. When a clear and a new edge fall in the same cycle, the edge wins and the bit stays set.
- R7: A write to offset 0x0C loads the enable bits. Request output i equals (pending[i] AND enable[i]) as it was one cycle earlier, so a cleared enable keeps the request low.
- R8: The node-control word and any other unused address read as zero, and writes to them change nothing. Register bits above the implemented pins read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_req | output | NUM_PINS | Registered interrupt request per pin |

## Verification
A software clear of a pending bit and a fresh edge on the same pin can land on the same clock edge. The bench provokes this by toggling a pin in either-edge mode and then timing the clear write so that it is sampled on the exact edge where the synchronized transition is detected. It judges the result by reading the pending register afterwards: the bit must still be set. A second clear, with the pin quiet, must then empty the bit. A near-exhaustive sweep of every pin, every one of the sixteen codes and both transition directions checks the pending and request values against an arithmetic model.

// File: rtl/eit_pkg.sv
package eit_pkg;

   // Trigger codes held in each 4-bit configuration nibble
   localparam logic [3:0] TRIG_NONE = 4'd0;
   localparam logic [3:0] TRIG_RISE = 4'd1;
   localparam logic [3:0] TRIG_FALL = 4'd2;
   localparam logic [3:0] TRIG_BOTH = 4'd3;
   localparam logic [3:0] TRIG_HIGH = 4'd5;
   localparam logic [3:0] TRIG_LOW  = 4'd6;

   localparam int unsigned CODE_W = 4;

   // Byte offsets of the register words
   localparam int unsigned OFS_CFG  = 0;
   localparam int unsigned OFS_NODE = 4;
   localparam int unsigned OFS_PEND = 8;
   localparam int unsigned OFS_EN   = 12;

   // True when the code selects a level-following mode
   function automatic logic is_level(input logic [3:0] code);
      return (code == TRIG_HIGH) || (code == TRIG_LOW);
   endfunction

   // Trigger condition for one pin, given current and previous synchronized value
   function automatic logic trig_hit(input logic [3:0] code, input logic cur, input logic prv);
      case (code)
         TRIG_RISE: return cur & ~prv;
         TRIG_FALL: return ~cur & prv;
         TRIG_BOTH: return cur ^ prv;
         TRIG_HIGH: return cur;
         TRIG_LOW:  return ~cur;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/eit_sync.sv
module eit_sync #(
   parameter int unsigned W      = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/eit_detect.sv
module eit_detect
   import eit_pkg::*;
#(
   parameter int unsigned NUM_PINS = 6,
   localparam int unsigned CFG_W   = NUM_PINS * CODE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_s,
   input  logic [CFG_W-1:0]    cfg,
   input  logic [NUM_PINS-1:0] clr,
   output logic [NUM_PINS-1:0] pend
);

   // Previous synchronized sample, for edge detection
   logic [NUM_PINS-1:0] prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= '0;
      else        prv <= pin_s;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [3:0] code;
      logic       hit;
      logic       pend_q;

      assign code = cfg[i*CODE_W +: CODE_W];
      assign hit  = trig_hit(code, pin_s[i], prv[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
         end else if (is_level(code)) begin
            // Level modes: the bit tracks the active level
            pend_q <= hit;
         end else begin
            // Edge or quiet modes: sticky; a new event outranks a clear
            pend_q <= hit | (pend_q & ~clr[i]);
         end
      end

      assign pend[i] = pend_q;
   end

endmodule

// File: rtl/eit_regs.sv
module eit_regs
   import eit_pkg::*;
#(
   parameter int unsigned NUM_PINS = 6,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   localparam int unsigned CFG_W   = NUM_PINS * CODE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [NUM_PINS-1:0] pend,
   output logic [CFG_W-1:0]    cfg,
   output logic [NUM_PINS-1:0] en,
   output logic [NUM_PINS-1:0] clr,
   output logic [DATA_W-1:0]   reg_rdata
);

   localparam logic [CFG_W-1:0] CFG_RST = {NUM_PINS{TRIG_LOW}};

   logic sel_cfg, sel_node, sel_pend, sel_en;
   logic unused_wbits;

   assign sel_cfg  = (reg_addr == ADDR_W'(OFS_CFG));
   assign sel_node = (reg_addr == ADDR_W'(OFS_NODE));
   assign sel_pend = (reg_addr == ADDR_W'(OFS_PEND));
   assign sel_en   = (reg_addr == ADDR_W'(OFS_EN));

   // Upper write bits have no storage behind them
   assign unused_wbits = ^{reg_wdata, sel_node};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RST;
         en  <= '0;
      end else if (reg_wr) begin
         if (sel_cfg) cfg <= reg_wdata[CFG_W-1:0];
         if (sel_en)  en  <= reg_wdata[NUM_PINS-1:0];
      end
   end

   // A zero written to a pending bit requests its clear
   assign clr = (reg_wr && sel_pend) ? ~reg_wdata[NUM_PINS-1:0] : '0;

   always_comb begin
      reg_rdata = '0;
      if (sel_cfg)       reg_rdata[CFG_W-1:0]    = cfg;
      else if (sel_pend) reg_rdata[NUM_PINS-1:0] = pend;
      else if (sel_en)   reg_rdata[NUM_PINS-1:0] = en;
   end

endmodule

// File: rtl/eit_unit.sv
module eit_unit
   import eit_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 6,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic [NUM_PINS-1:0] irq_req
);

   localparam int unsigned CFG_W = NUM_PINS * CODE_W;

   if (NUM_PINS < 1 || CFG_W > DATA_W) begin : g_bad_pins
      $error("eit_unit: NUM_PINS must be at least 1 and its codes must fit DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("eit_unit: ADDR_W must reach offset 0x0C");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("eit_unit: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pin_s_w;
   logic [CFG_W-1:0]    cfg_w;
   logic [NUM_PINS-1:0] en_w;
   logic [NUM_PINS-1:0] clr_w;
   logic [NUM_PINS-1:0] pend_w;

   eit_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (pin_s_w)
   );

   eit_detect #(.NUM_PINS(NUM_PINS)) u_detect (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_s(pin_s_w),
      .cfg  (cfg_w),
      .clr  (clr_w),
      .pend (pend_w)
   );

   eit_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .pend     (pend_w),
      .cfg      (cfg_w),
      .en       (en_w),
      .clr      (clr_w),
      .reg_rdata(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_req <= '0;
      else        irq_req <= pend_w & en_w;
   end

endmodule

// File: rtl/eit_unit_chk.sv
module eit_unit_chk
   import eit_pkg::*;
#(
   parameter int unsigned NUM_PINS = 6,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   localparam int unsigned CFG_W   = NUM_PINS * CODE_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_wr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic [NUM_PINS-1:0] irq_req,
   input logic [CFG_W-1:0]    cfg,
   input logic [NUM_PINS-1:0] en,
   input logic [NUM_PINS-1:0] pend,
   input logic [NUM_PINS-1:0] pin_s
);

   // R7
   req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_req == $past(pend & en)));

   // R7
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(OFS_EN)) |=> (en == $past(reg_wdata[NUM_PINS-1:0])));

   // R8
   node_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_NODE)) |-> (reg_rdata == '0));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [3:0] code;
      logic       quiet;
      assign code  = cfg[i*CODE_W +: CODE_W];
      assign quiet = !(code inside {TRIG_RISE, TRIG_FALL, TRIG_BOTH, TRIG_HIGH, TRIG_LOW});

      // R5
      quiet_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (quiet && !pend[i]) |=> !pend[i]);

      // R4
      level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (code == TRIG_HIGH) |=> (pend[i] == $past(pin_s[i])));
   end

endmodule

bind eit_unit eit_unit_chk #(
   .NUM_PINS(NUM_PINS),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_wr   (reg_wr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .irq_req  (irq_req),
   .cfg      (cfg_w),
   .en       (en_w),
   .pend     (pend_w),
   .pin_s    (pin_s_w)
);

// File: tb/eit_unit_test.sv
module eit_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 6;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] pins;
   logic [3:0]    addr;
   logic          wr;
   logic [31:0]   wdata;
   logic [31:0]   rdata;
   logic [NP-1:0] req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eit_unit #(.NUM_PINS(NP), .DATA_W(32), .ADDR_W(4), .SYNC_STAGES(2)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pins),
      .reg_addr (addr),
      .reg_wr   (wr),
      .reg_wdata(wdata),
      .reg_rdata(rdata),
      .irq_req  (req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a negedge; the write lands on the next posedge, returns at the following negedge
   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      addr  = a;
      wdata = d;
      wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic model(input int code, input logic a, input logic b);
      case (code)
         1: return !a && b;
         2: return a && !b;
         3: return a != b;
         5: return b;
         6: return !b;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0;
      pins  = '0;
      addr  = '0;
      wr    = 1'b0;
      wdata = '0;
      cycles(3);

      // R1 reset state
      reg_read(4'h0, v); chk("R1 cfg reset", v, 32'h0066_6666);
      reg_read(4'h8, v); chk("R1 pend reset", v, 32'h0);
      reg_read(4'hC, v); chk("R1 en reset", v, 32'h0);
      chk("R1 req reset", {26'd0, req}, 32'h0);
      rst_n = 1'b1;
      cycles(2);

      // R2 latency: rising mode on pin 0
      reg_write(4'h0, 32'h0000_0001);
      reg_write(4'hC, 32'h0000_0001);
      cycles(3);
      reg_write(4'h8, 32'h0);
      pins[0] = 1'b1;
      cycles(2);
      reg_read(4'h8, v); chk("R2 pend after edge 2", v, 32'h0);
      cycles(1);
      reg_read(4'h8, v); chk("R2 pend after edge 3", v, 32'h1);
      chk("R2 req after edge 3", {26'd0, req}, 32'h0);
      cycles(1);
      chk("R2 req after edge 4", {26'd0, req}, 32'h1);

      // R6 clear and edge in the same cycle (either-edge mode)
      reg_write(4'h0, 32'h0000_0003);
      pins[0] = 1'b0;
      cycles(2);
      reg_write(4'h8, 32'h0);          // sampled on the detection edge
      reg_read(4'h8, v); chk("R6 edge outranks clear", v, 32'h1);
      cycles(3);
      reg_write(4'h8, 32'h0);
      reg_read(4'h8, v); chk("R6 clear when quiet", v, 32'h0);
      reg_write(4'h8, 32'hFFFF_FFFF);
      reg_read(4'h8, v); chk("R6 writing ones sets nothing", v, 32'h0);

      // R4 clear ignored while level active, then bit drops
      reg_write(4'h0, 32'h0000_0006);
      cycles(4);
      reg_write(4'h8, 32'h0);
      reg_read(4'h8, v); chk("R4 clear no effect at active level", v, 32'h1);
      pins[0] = 1'b1;
      cycles(4);
      reg_read(4'h8, v); chk("R4 level inactive drops bit", v, 32'h0);

      // R7 enable gating
      pins[0] = 1'b0;
      reg_write(4'hC, 32'h0);
      cycles(5);
      chk("R7 disabled req low", {26'd0, req}, 32'h0);
      reg_write(4'hC, 32'h1);
      cycles(1);
      chk("R7 enabled req high", {26'd0, req}, 32'h1);

      // R8 node control and unused addresses
      reg_write(4'h4, 32'hFFFF_FFFF);
      reg_read(4'h4, v); chk("R8 node reads zero", v, 32'h0);
      reg_read(4'h0, v); chk("R8 cfg unchanged", v, 32'h0000_0006);
      reg_read(4'hC, v); chk("R8 en unchanged", v, 32'h0000_0001);
      reg_write(4'h2, 32'hFFFF_FFFF);
      reg_read(4'h2, v); chk("R8 unused addr zero", v, 32'h0);
      reg_write(4'hC, 32'hFFFF_FFFF);
      reg_read(4'hC, v); chk("R8 upper en bits zero", v, 32'h0000_003F);

      // R3 / R4 / R5 sweep: every pin, every code, both transitions
      for (int i = 0; i < NP; i++) begin
         for (int code = 0; code < 16; code++) begin
            for (int dir = 0; dir < 2; dir++) begin
               logic a, b, e;
               string tag;
               a = (dir == 1);
               b = !a;
               e = model(code, a, b);
               tag = (code >= 1 && code <= 3) ? "R3" :
                     (code == 5 || code == 6) ? "R4" : "R5";
               reg_write(4'h0, 32'(code) << (4 * i));
               pins = '0;
               pins[i] = a;
               cycles(4);
               reg_write(4'h8, 32'h0);
               pins[i] = b;
               cycles(5);
               reg_read(4'h8, v);
               chk($sformatf("%s sweep pend pin%0d code%0d dir%0d", tag, i, code, dir),
                   v, 32'(e) << i);
               chk($sformatf("%s sweep req pin%0d code%0d dir%0d", tag, i, code, dir),
                   {26'd0, req}, 32'(e) << i);
            end
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule